// File: doc/BRIEF.md
# Watchdog Timer with Paired-Clear Option

This block counts ticks from a selectable source until it overflows. When it overflows it raises a one-cycle reset request for the chip. Software prevents the time-out by issuing clear commands. Three sources can be selected: a free-running on-chip RC tick, the instruction-cycle tick, or none. With no source the watchdog is disabled. Each source tick enables the logic for one cycle of the single system clock `clk`. A power-of-two prescaler divides the chosen tick before it reaches the main counter.

A static option input chooses how clearing works. In single mode one clear strobe restarts the count. In paired mode two different clear strobes are needed, in either order, and they may also arrive in the same cycle. The first half of a pair is held until its partner arrives. This keeps a single runaway instruction from holding the watchdog off. The block also keeps two status flags: a time-out flag and a power-down flag. An accepted clear resets both flags, and entering halt sets the power-down flag.

Top module: `wdt_guard`

## Requirements
- R1: After reset `wdt_rst_o`, `to_o` and `pdf_o` are 0, and counting starts on the first clock after reset is released.
- R2: `src_sel_i` = 0 takes the tick from `rc_tick_i` and 1 takes it from `instr_tick_i`. Codes 2 and 3 disable the watchdog: the prescaler and counter hold their values and no time-out occurs.
- R3: Ratio code k on `ratio_i` (0 to 7) passes one prescaled tick for every 2^k source ticks. The first prescaled tick after a reset or an accepted clear comes on the 2^k-th source tick.
- R4: On the 2^CNT_W-th prescaled tick since the last reset or accepted clear, `wdt_rst_o` goes high for exactly one cycle. In the same cycle `to_o` becomes 1. Both are registered, so they rise in the cycle after that tick.
- R5: With `dual_clear_i` = 0, a `clr_single_i` strobe is an accepted clear, and `clr_a_i` and `clr_b_i` have no effect.
- R6: With `dual_clear_i` = 1, a clear is accepted only once both `clr_a_i` and `clr_b_i` have been seen, in either order or in the same cycle. `clr_single_i` has no effect in this mode.
- R7: In paired mode the first half is remembered until its partner arrives. Repeating the same half does not complete the pair.
- R8: An accepted clear sets the counter, the prescaler and any remembered half to zero, and sets `to_o` and `pdf_o` to 0.
- R9: If an accepted clear and an overflow fall in the same cycle, the clear wins: there is no reset pulse and `to_o` stays 0.
- R10: A `halt_i` strobe sets `pdf_o` to 1 on the next cycle. If a halt and an accepted clear fall in the same cycle, `pdf_o` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel_i | input | 2 | Tick source: 0 RC, 1 instruction, 2/3 off |
| rc_tick_i | input | 1 | One-cycle tick from the on-chip RC clock |
| instr_tick_i | input | 1 | One-cycle tick per instruction cycle |
| dual_clear_i | input | 1 | Static option: 0 single clear, 1 paired clear |
| clr_single_i | input | 1 | Single clear command strobe |
| clr_a_i | input | 1 | First paired clear command strobe |
| clr_b_i | input | 1 | Second paired clear command strobe |
| halt_i | input | 1 | Halt entry strobe |
| ratio_i | input | RATIO_W | Prescaler ratio code k, divide by 2^k |
| wdt_rst_o | output | 1 | One-cycle chip reset request |
| to_o | output | 1 | Time-out flag |
| pdf_o | output | 1 | Power-down flag |

## Verification
The overflow and an accepted clear can fall in the same cycle. To provoke this, the bench lets the counter reach its top value and then strobes the clear on the very tick that would overflow it. It then confirms that no reset pulse appears and that `to_o` stays 0. After that, a full 2^CNT_W ticks must pass before the next time-out. A halt coinciding with a clear is judged the same way, by reading `pdf_o` on the cycle that follows.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    SRC_RC    = 2'd0,
    SRC_INSTR = 2'd1,
    SRC_OFF_A = 2'd2,
    SRC_OFF_B = 2'd3
  } wdt_src_e;
endpackage

// File: rtl/wdt_src_sel.sv
module wdt_src_sel
  import wdt_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic       rc_tick_i,
  input  logic       instr_tick_i,
  output logic       tick_o
);
  always_comb begin
    unique case (wdt_src_e'(sel_i))
      SRC_RC:    tick_o = rc_tick_i;
      SRC_INSTR: tick_o = instr_tick_i;
      default:   tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_i,
  input  logic               tick_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               tick_o
);
  localparam int PS_W = (1 << RATIO_W) - 1;

  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] mask;

  for (genvar i = 0; i < PS_W; i++) begin : g_mask
    assign mask[i] = (RATIO_W'(i) < ratio_i);
  end

  assign tick_o = tick_i && ((ps_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr_i) ps_q <= '0;
    else if (tick_i)  ps_q <= ps_q + 1'b1;
  end

  AST_RATIO_ONE_PASS: assert property (@(posedge clk) disable iff (rst)
    (ratio_i == '0 && tick_i) |-> tick_o); // R3
  AST_PS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !clr_i) |=> $stable(ps_q)); // R2
endmodule

// File: rtl/wdt_clear_pair.sv
module wdt_clear_pair (
  input  logic clk,
  input  logic rst,
  input  logic dual_i,
  input  logic clr_single_i,
  input  logic clr_a_i,
  input  logic clr_b_i,
  output logic accept_o
);
  logic seen_a_q, seen_b_q;
  logic pair_done;

  assign pair_done = (clr_a_i || seen_a_q) && (clr_b_i || seen_b_q);
  assign accept_o  = dual_i ? pair_done : clr_single_i;

  always_ff @(posedge clk) begin
    if (rst || !dual_i || pair_done) begin
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
    end else begin
      if (clr_a_i) seen_a_q <= 1'b1;
      if (clr_b_i) seen_b_q <= 1'b1;
    end
  end

  AST_SINGLE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!dual_i && !clr_single_i) |-> !accept_o); // R5
  AST_PAIR_NEEDS_B: assert property (@(posedge clk) disable iff (rst)
    (dual_i && !clr_b_i && !seen_b_q) |-> !accept_o); // R7
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic tick_i,
  output logic ovf_o
);
  logic [CNT_W-1:0] cnt_q;

  assign ovf_o = tick_i && (&cnt_q) && !clr_i;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !clr_i) |=> $stable(cnt_q)); // R2
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int CNT_W   = 8,
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         src_sel_i,
  input  logic               rc_tick_i,
  input  logic               instr_tick_i,
  input  logic               dual_clear_i,
  input  logic               clr_single_i,
  input  logic               clr_a_i,
  input  logic               clr_b_i,
  input  logic               halt_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               wdt_rst_o,
  output logic               to_o,
  output logic               pdf_o
);
  logic src_tick, pre_tick, accept, ovf;

  wdt_src_sel u_src (
    .sel_i(src_sel_i), .rc_tick_i(rc_tick_i),
    .instr_tick_i(instr_tick_i), .tick_o(src_tick)
  );

  wdt_prescaler #(.RATIO_W(RATIO_W)) u_ps (
    .clk(clk), .rst(rst), .clr_i(accept), .tick_i(src_tick),
    .ratio_i(ratio_i), .tick_o(pre_tick)
  );

  wdt_clear_pair u_pair (
    .clk(clk), .rst(rst), .dual_i(dual_clear_i),
    .clr_single_i(clr_single_i), .clr_a_i(clr_a_i), .clr_b_i(clr_b_i),
    .accept_o(accept)
  );

  wdt_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(accept), .tick_i(pre_tick), .ovf_o(ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wdt_rst_o <= 1'b0;
      to_o      <= 1'b0;
      pdf_o     <= 1'b0;
    end else begin
      wdt_rst_o <= ovf;
      if (accept)   to_o <= 1'b0;
      else if (ovf) to_o <= 1'b1;
      if (halt_i)      pdf_o <= 1'b1;
      else if (accept) pdf_o <= 1'b0;
    end
  end

  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_o |=> !wdt_rst_o); // R4
  AST_TO_WITH_PULSE: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_o |-> to_o); // R4
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!wdt_rst_o && !to_o)); // R9
  AST_HALT_PDF: assert property (@(posedge clk) disable iff (rst)
    halt_i |=> pdf_o); // R10
  AST_CLEAR_PDF: assert property (@(posedge clk) disable iff (rst)
    (accept && !halt_i) |=> !pdf_o); // R8
endmodule

// File: tb/tb_wdt_guard.sv
module tb_wdt_guard;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] src_sel = 2'd1;
  logic rc_tick = 1'b1, instr_tick = 1'b1;
  logic dual = 1'b0, clr_s = 1'b0, clr_a = 1'b0, clr_b = 1'b0, halt = 1'b0;
  logic [2:0] ratio = 3'd0;
  logic wdt_rst, to_f, pdf_f;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  wdt_guard dut (
    .clk(clk), .rst(rst), .src_sel_i(src_sel), .rc_tick_i(rc_tick),
    .instr_tick_i(instr_tick), .dual_clear_i(dual), .clr_single_i(clr_s),
    .clr_a_i(clr_a), .clr_b_i(clr_b), .halt_i(halt), .ratio_i(ratio),
    .wdt_rst_o(wdt_rst), .to_o(to_f), .pdf_o(pdf_f)
  );

  // {sel[1:0], ratio[2:0], steps[15:0], exp_rst, exp_to}
  localparam logic [22:0] VECS [0:12] = '{
    {2'd1, 3'd0, 16'd255,   1'b0, 1'b0},  // R4
    {2'd1, 3'd0, 16'd256,   1'b1, 1'b1},  // R4
    {2'd1, 3'd0, 16'd257,   1'b0, 1'b1},  // R4
    {2'd1, 3'd1, 16'd511,   1'b0, 1'b0},  // R3
    {2'd1, 3'd1, 16'd512,   1'b1, 1'b1},  // R3
    {2'd1, 3'd3, 16'd2047,  1'b0, 1'b0},  // R3
    {2'd1, 3'd3, 16'd2048,  1'b1, 1'b1},  // R3
    {2'd1, 3'd7, 16'd32767, 1'b0, 1'b0},  // R3
    {2'd1, 3'd7, 16'd32768, 1'b1, 1'b1},  // R3
    {2'd0, 3'd0, 16'd510,   1'b0, 1'b0},  // R2
    {2'd0, 3'd0, 16'd511,   1'b1, 1'b1},  // R2
    {2'd2, 3'd0, 16'd600,   1'b0, 1'b0},  // R2
    {2'd3, 3'd0, 16'd600,   1'b0, 1'b0}   // R2
  };

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    rc_tick = ~rc_tick;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset(input logic dmode);
    rst = 1'b1; dual = dmode;
    clr_s = 0; clr_a = 0; clr_b = 0; halt = 0;
    run(2);
    rst = 1'b0; rc_tick = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    src_sel = 2'd1; ratio = 3'd0;
    do_reset(1'b0);
    check("R1 rst", wdt_rst, 1'b0);
    check("R1 to", to_f, 1'b0);
    check("R1 pdf", pdf_f, 1'b0);

    for (int v = 0; v < 13; v++) begin
      src_sel = VECS[v][22:21];
      ratio   = VECS[v][20:18];
      do_reset(1'b0);
      run(int'(VECS[v][17:2]));
      check($sformatf("R2/R3/R4 vec%0d rst", v), wdt_rst, VECS[v][1]);
      check($sformatf("R2/R3/R4 vec%0d to", v), to_f, VECS[v][0]);
    end

    // R2: disabled source holds the count
    src_sel = 2'd1; ratio = 3'd0; do_reset(1'b0);
    run(100); src_sel = 2'd2; run(1000); src_sel = 2'd1;
    run(155); check("R2 hold early", wdt_rst, 1'b0);
    run(1);   check("R2 hold overflow", wdt_rst, 1'b1);

    // R5: single clear restarts; pair strobes ignored
    do_reset(1'b0);
    run(200); clr_s = 1; step(); clr_s = 0;
    run(255); check("R5 cleared early", wdt_rst, 1'b0);
    run(1);   check("R5 cleared overflow", wdt_rst, 1'b1);
    do_reset(1'b0);
    run(100); clr_a = 1; step(); clr_a = 0; clr_b = 1; step(); clr_b = 0;
    run(154); check("R5 pair ignored", wdt_rst, 1'b1);

    // R9: clear on the overflowing tick
    do_reset(1'b0);
    run(255); clr_s = 1; step(); clr_s = 0;
    check("R9 no pulse", wdt_rst, 1'b0);
    check("R9 to stays", to_f, 1'b0);
    run(255); check("R9 restart early", wdt_rst, 1'b0);
    run(1);   check("R9 restart overflow", wdt_rst, 1'b1);

    // R8: clear zeroes TO, PDF and the prescaler
    run(3); check("R8 to set", to_f, 1'b1);
    halt = 1; step(); halt = 0; check("R10 halt pdf", pdf_f, 1'b1);
    clr_s = 1; halt = 1; step(); clr_s = 0; halt = 0;
    check("R10 halt with clear", pdf_f, 1'b1);
    check("R8 to cleared", to_f, 1'b0);
    clr_s = 1; step(); clr_s = 0;
    check("R8 pdf cleared", pdf_f, 1'b0);
    ratio = 3'd1; do_reset(1'b0);
    run(1); clr_s = 1; step(); clr_s = 0;
    run(511); check("R8 prescaler cleared early", wdt_rst, 1'b0);
    run(1);   check("R8 prescaler cleared overflow", wdt_rst, 1'b1);

    // R6: paired mode, single strobe ignored
    ratio = 3'd0; do_reset(1'b1);
    run(100); clr_s = 1; step(); clr_s = 0;
    run(155); check("R6 single ignored", wdt_rst, 1'b1);

    // R7: repeating the same half does not complete
    do_reset(1'b1);
    run(100); clr_a = 1; step(); clr_a = 0;
    run(50);  clr_a = 1; step(); clr_a = 0;
    run(104); check("R7 repeat no clear", wdt_rst, 1'b1);

    // R6/R7: half remembered, partner completes
    do_reset(1'b1);
    run(200); clr_a = 1; step(); clr_a = 0;
    run(50);  clr_b = 1; step(); clr_b = 0;
    run(255); check("R7 pair early", wdt_rst, 1'b0);
    run(1);   check("R7 pair overflow", wdt_rst, 1'b1);

    // R6: both halves in one cycle, b first then a
    do_reset(1'b1);
    run(200); clr_a = 1; clr_b = 1; step(); clr_a = 0; clr_b = 0;
    run(255); check("R6 same cycle early", wdt_rst, 1'b0);
    do_reset(1'b1);
    run(200); clr_b = 1; step(); clr_b = 0; clr_a = 1; step(); clr_a = 0;
    run(255); check("R6 b then a early", wdt_rst, 1'b0);
    run(1);   check("R6 b then a overflow", wdt_rst, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule